// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor. The distributor presents its current best candidate as a valid flag, a 10-bit source ID and an 8-bit priority value, where a lower value means a more urgent interrupt. The block decides whether that candidate may interrupt the processor and drives a registered request line. The decision takes three things into account: a software enable, a priority threshold, and the priority of whatever handler is already running.

Software reaches the block through a small word-addressed register port. A read of the acknowledge register claims the candidate. The read returns its ID, pushes its ID and priority onto an active-priority stack, and sends a one-cycle acknowledge strobe back to the distributor. A write of the same ID to the end-of-interrupt register retires the newest active interrupt. This pops the stack and sends a completion strobe. Nested preemption is therefore limited to candidates strictly more urgent than the newest unretired one, up to the stack depth.

Top module: `intack_cpu_if`

## Requirements
- R1: After reset the request line and both strobes are low, and reads of the control and threshold registers return 0.
- R2: The register port uses word addresses: 0 is control (bit 0 enables signalling), 1 is the threshold (bits 7:0), 2 is acknowledge (read) and 3 is end-of-interrupt (write). Read data appears on bus_rdata in the cycle after the read. Other addresses read as 0.
- R3: A candidate qualifies when dist_valid is high and all the other conditions in this list are met. The request line goes high one clock edge after the candidate qualifies with signalling enabled, and goes low one edge after it stops qualifying.
- R4: A candidate qualifies only if its priority value is strictly lower than the threshold. A priority value equal to the threshold does not qualify.
- R5: A read of acknowledge while a candidate qualifies returns its ID in bits 9:0, with all upper bits zero. The same read pulses ack_strobe for one cycle with ack_id equal to that ID, and pushes the candidate onto the active stack.
- R6: A read of acknowledge while nothing qualifies returns 1023. It raises no strobe and leaves the active stack unchanged.
- R7: A candidate whose ID is above 1020 never qualifies.
- R8: While the stack holds entries, a candidate qualifies only if its priority value is strictly lower than the priority of the newest entry.
- R9: A write to end-of-interrupt whose full 32-bit data equals the ID of the newest entry pops that entry and pulses eoi_strobe with eoi_id set to that ID. Any other write, or any write while the stack is empty, has no effect.
- R10: The active stack holds 4 entries. While it is full, no candidate qualifies.
- R11: While control bit 0 is 0, the request line stays low and acknowledge reads return 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| dist_valid | input | 1 | Distributor has a candidate |
| dist_id | input | 10 | Candidate source ID |
| dist_prio | input | 8 | Candidate priority value (lower is more urgent) |
| irq_o | output | 1 | Registered interrupt request to the processor |
| ack_strobe | output | 1 | One-cycle pulse when a candidate is claimed |
| ack_id | output | 10 | ID of the claimed candidate |
| eoi_strobe | output | 1 | One-cycle pulse when an interrupt is retired |
| eoi_id | output | 10 | ID of the retired interrupt |

## Verification
Directed sequences separate the qualification conditions one at a time. They use priority values equal to and one below the threshold, an ID of 1021 against one of 40, a candidate at the running priority against one just below it, a full stack, and a cleared enable. Each case shows which single condition gates the request line and the acknowledge result. Retire writes with a non-matching ID and with the matching ID distinguish a real pop from an ignored write. After the directed cases, a seeded random mix of candidate changes, claims, retires, threshold and enable writes, and stray reads runs against a bench model of the stack. This mix covers nesting depths and orderings that the directed cases do not reach.

// File: rtl/intack_pkg.sv
package intack_pkg;

    localparam int ID_W        = 10;
    localparam int PRIO_W      = 8;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int STACK_DEPTH = 4;

    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam logic [ID_W-1:0] MAX_SRC_ID  = 10'd1020;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_THRESH = 3'd1,
        REG_CLAIM = 3'd2,
        REG_DONE  = 3'd3
    } reg_addr_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } act_entry_t;

endpackage

// File: rtl/intack_qualify.sv
module intack_qualify
    import intack_pkg::*;
(
    input  logic              en,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] thresh,
    input  logic              stk_empty,
    input  logic              stk_full,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              hit
);

    logic id_ok;
    logic below_thresh;
    logic preempts;

    always_comb begin
        id_ok        = (cand_id <= MAX_SRC_ID);
        below_thresh = (cand_prio < thresh);
        // an empty stack means no handler is running, so nothing restricts
        preempts     = stk_empty || (cand_prio < run_prio);
        hit          = en && cand_valid && id_ok && below_thresh
                       && preempts && !stk_full;
    end

endmodule

// File: rtl/intack_prio_stack.sv
module intack_prio_stack
    import intack_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  act_entry_t        push_entry,
    output act_entry_t        top_entry,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  depth
);

    typedef struct packed {
        act_entry_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]       cnt;
    } stk_st_t;

    stk_st_t st_d, st_q;
    act_entry_t [DEPTH-1:0] ent_nxt;
    logic push_ok;
    logic pop_ok;

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign depth = st_q.cnt;
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty && !push_ok;

    // one write port per slot: a slot loads only when it is the next free one
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign ent_nxt[i] = (push_ok && st_q.cnt == CNT_W'(i)) ? push_entry
                                                              : st_q.ent[i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.ent = ent_nxt;
        if (push_ok) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (pop_ok) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_comb begin
        top_entry = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.cnt == CNT_W'(i + 1)) begin
                top_entry = st_q.ent[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/intack_cpu_if.sv
module intack_cpu_if
    import intack_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dist_valid,
    input  logic [ID_W-1:0]   dist_id,
    input  logic [PRIO_W-1:0] dist_prio,
    output logic              irq_o,
    output logic              ack_strobe,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_strobe,
    output logic [ID_W-1:0]   eoi_id
);

    typedef struct packed {
        logic              ctrl_en;
        logic [PRIO_W-1:0] thresh;
        logic [DATA_W-1:0] rdata;
        logic              irq;
        logic              ack_stb;
        logic [ID_W-1:0]   ack_id;
        logic              eoi_stb;
        logic [ID_W-1:0]   eoi_id;
    } cif_st_t;

    cif_st_t st_d, st_q;

    logic             rd_acc;
    logic             wr_acc;
    logic             claim_rd;
    logic             done_wr;
    logic             hit;
    logic             stk_push;
    logic             stk_pop;
    logic             stk_empty;
    logic             stk_full;
    logic [CNT_W-1:0] stk_depth;
    logic             ctrl_en;
    act_entry_t       cand;
    act_entry_t       top_ent;
    reg_addr_e        addr_e;

    assign addr_e   = reg_addr_e'(bus_addr);
    assign rd_acc   = bus_sel && !bus_wr;
    assign wr_acc   = bus_sel && bus_wr;
    assign claim_rd = rd_acc && (addr_e == REG_CLAIM);
    assign done_wr  = wr_acc && (addr_e == REG_DONE);
    assign ctrl_en  = st_q.ctrl_en;
    assign cand     = '{id: dist_id, prio: dist_prio};

    intack_qualify u_qual (
        .en         (st_q.ctrl_en),
        .cand_valid (dist_valid),
        .cand_id    (dist_id),
        .cand_prio  (dist_prio),
        .thresh     (st_q.thresh),
        .stk_empty  (stk_empty),
        .stk_full   (stk_full),
        .run_prio   (top_ent.prio),
        .hit        (hit)
    );

    intack_prio_stack #(
        .DEPTH (DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (stk_push),
        .pop        (stk_pop),
        .push_entry (cand),
        .top_entry  (top_ent),
        .empty      (stk_empty),
        .full       (stk_full),
        .depth      (stk_depth)
    );

    always_comb begin
        st_d         = st_q;
        st_d.irq     = hit;
        st_d.ack_stb = 1'b0;
        st_d.eoi_stb = 1'b0;
        stk_push     = 1'b0;
        stk_pop      = 1'b0;

        if (rd_acc) begin
            unique case (addr_e)
                REG_CTRL:   st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.ctrl_en};
                REG_THRESH: st_d.rdata = {{(DATA_W-PRIO_W){1'b0}}, st_q.thresh};
                REG_CLAIM: begin
                    if (hit) begin
                        st_d.rdata   = {{(DATA_W-ID_W){1'b0}}, dist_id};
                        st_d.ack_stb = 1'b1;
                        st_d.ack_id  = dist_id;
                        stk_push     = 1'b1;
                    end else begin
                        st_d.rdata = {{(DATA_W-ID_W){1'b0}}, SPURIOUS_ID};
                    end
                end
                default:    st_d.rdata = '0;
            endcase
        end

        if (wr_acc) begin
            unique case (addr_e)
                REG_CTRL:   st_d.ctrl_en = bus_wdata[0];
                REG_THRESH: st_d.thresh  = bus_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end

        // retire only the newest entry, matched on the whole data word
        if (done_wr && !stk_empty
            && bus_wdata == {{(DATA_W-ID_W){1'b0}}, top_ent.id}) begin
            stk_pop      = 1'b1;
            st_d.eoi_stb = 1'b1;
            st_d.eoi_id  = top_ent.id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign irq_o      = st_q.irq;
    assign ack_strobe = st_q.ack_stb;
    assign ack_id     = st_q.ack_id;
    assign eoi_strobe = st_q.eoi_stb;
    assign eoi_id     = st_q.eoi_id;

endmodule

// File: rtl/intack_chk.sv
module intack_chk
    import intack_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             irq,
    input logic             claim_rd,
    input logic             ack_stb,
    input logic [ID_W-1:0]  ack_id,
    input logic             eoi_stb,
    input logic [CNT_W-1:0] depth
);

    p_gate_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !irq)
        else $error("p_gate_low_r11");

    p_valid_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |-> (ack_id <= MAX_SRC_ID))
        else $error("p_valid_id_r7");

    p_depth_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH))
        else $error("p_depth_cap_r10");

    p_claim_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |-> depth == $past(depth) + CNT_W'(1))
        else $error("p_claim_push_r5");

    p_spurious_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(claim_rd) && !ack_stb) |-> depth == $past(depth))
        else $error("p_spurious_still_r6");

    p_retire_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb |-> depth + CNT_W'(1) == $past(depth))
        else $error("p_retire_pop_r9");

    p_no_both_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_stb && eoi_stb))
        else $error("p_no_both_strobes_r9");

endmodule

bind intack_cpu_if intack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_en),
    .irq      (irq_o),
    .claim_rd (claim_rd),
    .ack_stb  (ack_strobe),
    .ack_id   (ack_id),
    .eoi_stb  (eoi_strobe),
    .depth    (stk_depth)
);

// File: tb/intack_cpu_if_tb.sv
module intack_cpu_if_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dist_valid = 1'b0;
    logic [9:0]  dist_id = '0;
    logic [7:0]  dist_prio = '0;
    logic        irq_o;
    logic        ack_strobe;
    logic [9:0]  ack_id;
    logic        eoi_strobe;
    logic [9:0]  eoi_id;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic       dv = 1'b0;
    logic [9:0] did = '0;
    logic [7:0] dp = '0;
    logic       m_en = 1'b0;
    logic [7:0] m_thr = '0;
    int         m_cnt = 0;
    logic [9:0] m_id [4];
    logic [7:0] m_prio [4];

    always #10 clk = ~clk;

    intack_cpu_if u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dist_valid (dist_valid),
        .dist_id    (dist_id),
        .dist_prio  (dist_prio),
        .irq_o      (irq_o),
        .ack_strobe (ack_strobe),
        .ack_id     (ack_id),
        .eoi_strobe (eoi_strobe),
        .eoi_id     (eoi_id)
    );

    function automatic logic mqual();
        logic q;
        q = m_en && dv && (did <= 10'd1020) && (dp < m_thr) && (m_cnt < 4);
        if (m_cnt > 0 && !(dp < m_prio[m_cnt-1])) q = 1'b0;
        return q;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic sel, input logic wr, input logic [2:0] addr,
                        input logic [31:0] wd, input string tag);
        logic        q;
        logic        is_rd;
        logic [31:0] e_rd;
        logic        e_ack;
        logic [9:0]  e_aid;
        logic        e_eoi;
        logic [9:0]  e_eid;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        dist_valid = dv; dist_id = did; dist_prio = dp;
        q = mqual();
        is_rd = sel && !wr;
        e_rd = '0; e_ack = 1'b0; e_aid = '0; e_eoi = 1'b0; e_eid = '0;
        if (is_rd) begin
            case (addr)
                3'd0: e_rd = {31'b0, m_en};
                3'd1: e_rd = {24'b0, m_thr};
                3'd2: begin
                    if (q) begin
                        e_rd = {22'b0, did}; e_ack = 1'b1; e_aid = did;
                        m_id[m_cnt] = did; m_prio[m_cnt] = dp; m_cnt++;
                    end else begin
                        e_rd = 32'd1023;
                    end
                end
                default: e_rd = '0;
            endcase
        end
        if (sel && wr) begin
            case (addr)
                3'd0: m_en = wd[0];
                3'd1: m_thr = wd[7:0];
                3'd3: if (m_cnt > 0 && wd == {22'b0, m_id[m_cnt-1]}) begin
                    e_eoi = 1'b1; e_eid = m_id[m_cnt-1]; m_cnt--;
                end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        chk({31'b0, irq_o}, {31'b0, q}, tag, "irq");
        chk({31'b0, ack_strobe}, {31'b0, e_ack}, tag, "ack_strobe");
        if (e_ack) chk({22'b0, ack_id}, {22'b0, e_aid}, tag, "ack_id");
        chk({31'b0, eoi_strobe}, {31'b0, e_eoi}, tag, "eoi_strobe");
        if (e_eoi) chk({22'b0, eoi_id}, {22'b0, e_eid}, tag, "eoi_id");
        if (is_rd) chk(bus_rdata, e_rd, tag, "rdata");
        bus_sel = 1'b0;
    endtask

    task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p);
        dv = v; did = id; dp = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk({31'b0, irq_o}, 32'd0, "R1", "irq");
        chk({31'b0, ack_strobe}, 32'd0, "R1", "ack_strobe");
        chk({31'b0, eoi_strobe}, 32'd0, "R1", "eoi_strobe");
        step(1'b1, 1'b0, 3'd0, 0, "R1");
        step(1'b1, 1'b0, 3'd1, 0, "R1");

        // R2 register map and read-back
        step(1'b1, 1'b1, 3'd0, 32'h1, "R2");
        step(1'b1, 1'b1, 3'd1, 32'hF0, "R2");
        step(1'b1, 1'b0, 3'd0, 0, "R2");
        step(1'b1, 1'b0, 3'd1, 0, "R2");
        step(1'b1, 1'b0, 3'd6, 0, "R2");

        // R3 request follows qualification one edge later
        cand(1'b1, 10'd40, 8'h80);
        step(1'b0, 1'b0, 3'd0, 0, "R3");
        step(1'b0, 1'b0, 3'd0, 0, "R3");
        cand(1'b0, 10'd40, 8'h80);
        step(1'b0, 1'b0, 3'd0, 0, "R3");

        // R4 threshold is strict
        cand(1'b1, 10'd50, 8'hF0);
        step(1'b0, 1'b0, 3'd0, 0, "R4");
        step(1'b1, 1'b0, 3'd2, 0, "R4");
        cand(1'b1, 10'd50, 8'hEF);
        step(1'b0, 1'b0, 3'd0, 0, "R4");

        // R7 ids above 1020
        cand(1'b1, 10'd1021, 8'h10);
        step(1'b0, 1'b0, 3'd0, 0, "R7");
        step(1'b1, 1'b0, 3'd2, 0, "R7");

        // R5 claim
        cand(1'b1, 10'd40, 8'h80);
        step(1'b1, 1'b0, 3'd2, 0, "R5");
        // R8 same priority does not preempt, lower value does
        step(1'b0, 1'b0, 3'd0, 0, "R8");
        step(1'b1, 1'b0, 3'd2, 0, "R8");
        cand(1'b1, 10'd41, 8'h7F);
        step(1'b0, 1'b0, 3'd0, 0, "R8");
        step(1'b1, 1'b0, 3'd2, 0, "R8");

        // R9 mismatched retire ignored, matching one pops
        cand(1'b0, 10'd0, 8'h00);
        step(1'b1, 1'b1, 3'd3, 32'd40, "R9");
        step(1'b1, 1'b1, 3'd3, 32'h0400_0029, "R9");
        step(1'b1, 1'b1, 3'd3, 32'd41, "R9");

        // R10 fill to depth 4
        cand(1'b1, 10'd60, 8'h70); step(1'b1, 1'b0, 3'd2, 0, "R10");
        cand(1'b1, 10'd61, 8'h60); step(1'b1, 1'b0, 3'd2, 0, "R10");
        cand(1'b1, 10'd62, 8'h50); step(1'b1, 1'b0, 3'd2, 0, "R10");
        cand(1'b1, 10'd63, 8'h10);
        step(1'b0, 1'b0, 3'd0, 0, "R10");
        step(1'b1, 1'b0, 3'd2, 0, "R10");

        // R6 nothing pending: spurious and stack unchanged
        cand(1'b0, 10'd63, 8'h10);
        step(1'b1, 1'b0, 3'd2, 0, "R6");
        step(1'b1, 1'b1, 3'd3, 32'd62, "R6");
        step(1'b1, 1'b1, 3'd3, 32'd61, "R6");

        // R11 disabled signalling
        cand(1'b1, 10'd70, 8'h05);
        step(1'b1, 1'b1, 3'd0, 32'h0, "R11");
        step(1'b0, 1'b0, 3'd0, 0, "R11");
        step(1'b1, 1'b0, 3'd2, 0, "R11");
        step(1'b1, 1'b1, 3'd0, 32'h1, "R11");
        step(1'b0, 1'b0, 3'd0, 0, "R11");

        // seeded random mix
        for (int it = 0; it < 5000; it++) begin
            int r;
            if ($urandom % 4 == 0)
                cand(($urandom % 8) != 0, 10'($urandom % 1024), 8'($urandom % 256));
            r = $urandom % 100;
            if (r < 25)
                step(1'b1, 1'b0, 3'd2, 0, "R5/R6/R8");
            else if (r < 42)
                step(1'b1, 1'b1, 3'd3,
                     (m_cnt > 0) ? {22'b0, m_id[m_cnt-1]} : 32'($urandom % 1024), "R9");
            else if (r < 47)
                step(1'b1, 1'b1, 3'd3, 32'($urandom % 1024), "R9");
            else if (r < 52)
                step(1'b1, 1'b0, 3'($urandom % 8), 0, "R2");
            else if (r < 55)
                step(1'b1, 1'b1, 3'd1, ($urandom % 2) ? 32'hF0 : 32'($urandom), "R4");
            else if (r < 57)
                step(1'b1, 1'b1, 3'd0, 32'(($urandom % 4) != 0), "R11");
            else
                step(1'b0, 1'b0, 3'd0, 0, "R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule